// File: doc/BRIEF.md
# Sparse Address Region Mapper

This block turns a processor byte address into an offset inside one dense backing store. The store is laid out as three pieces packed end to end: a power-of-two boot image, a low working area placed right after it, and a high area that holds the top of the address space. Between the end of the low area and the start of the high area lies an unmapped gap. Any access that lands in the gap is flagged as a fault and steered to a harmless scratch offset, so that it does not touch real storage.

The address is cut to 24 bits first. Anything under 1 MB repeats the boot image, so the image appears again and again across that range. Two 4 KB pages at the top of the high area each expose only a 1 KB window, which repeats four times. The boot image size, the end of the low area and the start of the high area are configuration inputs. A low-area end set under 1 MB is treated as exactly 1 MB. Each request produces a registered result one cycle later. The result stays on the outputs until the next request, so the core can sample the fault flag when it retires the instruction.

Top module: `sparse_region_mapper`

## Requirements
- R1: Only the low 24 bits of `req_addr` take part in the mapping, so the upper bits have no effect on the result.
- R2: An address under 0x100000 maps to `address & (cfg_rom_size - 1)`, where `cfg_rom_size` is a power of two, and gives no fault.
- R3: An address from 0x100000 up to, but not including, the effective low end maps to `address - 0x100000 + cfg_rom_size` and gives no fault.
- R4: An address at or above `cfg_high_start` that does not fall in the low area maps to `address - cfg_high_start + high_base`, where `high_base = cfg_rom_size + (effective low end - 0x100000)`, and gives no fault.
- R5: In the high area, an address at or above 0xFFF000 is first ANDed with 0xFFF3FF. Otherwise, an address at or above 0xFFE000 is first ANDed with 0xFFE3FF. In both pages a 1 KB window repeats four times.
- R6: An address at or above the effective low end and under `cfg_high_start` sets `rsp_fault` to 1 and gives the scratch offset 0xFFFFFF.
- R7: A `cfg_low_end` value under 0x100000 behaves as 0x100000, for the low area and for `high_base`.
- R8: `rsp_valid` pulses high for one cycle, in the cycle after each `req_valid`. Without a request, `rsp_offset` and `rsp_fault` keep their last values.
- R9: After synchronous reset, `rsp_valid`, `rsp_fault` and `rsp_offset` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| req_addr | input | 32 | Processor byte address |
| cfg_rom_size | input | 24 | Boot image size, a power of two |
| cfg_low_end | input | 24 | Exclusive end of the low area |
| cfg_high_start | input | 24 | First address of the high area |
| rsp_valid | output | 1 | Result of the previous cycle's request |
| rsp_offset | output | 24 | Offset into the backing store |
| rsp_fault | output | 1 | The address fell in the unmapped gap |

## Verification
The bench uses the default parameters: a 32-bit input address, 24 mapped bits, scratch offset 0xFFFFFF, and window aliasing turned on. The aliasing pages at 0xFFE000 and 0xFFF000 can therefore be reached from the high area. The bench places the high area below both pages, at 0xFFC000, so that the plain high mapping, both aliasing masks and the gap edges on either side are all exercised. It also switches to a 4 KB boot image and to a low end under 1 MB, which exercises repetition at a different size and the clamping of the low end.

// File: rtl/mapper_pkg.sv
package mapper_pkg;
  typedef enum logic [1:0] {
    RGN_BOOT = 2'd0,
    RGN_LOW  = 2'd1,
    RGN_HIGH = 2'd2,
    RGN_GAP  = 2'd3
  } region_e;
endpackage

// File: rtl/mapper_cfg.sv
module mapper_cfg #(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] LOW_FLOOR = 24'h100000
) (
  input  logic [ADDR_W-1:0] rom_size,
  input  logic [ADDR_W-1:0] low_end,
  output logic [ADDR_W-1:0] low_end_eff,
  output logic [ADDR_W-1:0] high_base
);
  always_comb begin
    low_end_eff = (low_end < LOW_FLOOR) ? LOW_FLOOR : low_end;
    high_base   = rom_size + (low_end_eff - LOW_FLOOR);
  end
endmodule

// File: rtl/mapper_classify.sv
module mapper_classify
  import mapper_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] LOW_FLOOR = 24'h100000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] low_end_eff,
  input  logic [ADDR_W-1:0] high_start,
  output region_e           region
);
  always_comb begin
    if (addr < LOW_FLOOR)             region = RGN_BOOT;
    else if (addr < low_end_eff)      region = RGN_LOW;
    else if (addr >= high_start)      region = RGN_HIGH;
    else                              region = RGN_GAP;
  end
endmodule

// File: rtl/mapper_offset.sv
module mapper_offset
  import mapper_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] LOW_FLOOR = 24'h100000,
  parameter logic [ADDR_W-1:0] PG1_BASE  = 24'hFFF000,
  parameter logic [ADDR_W-1:0] PG1_MASK  = 24'hFFF3FF,
  parameter logic [ADDR_W-1:0] PG0_BASE  = 24'hFFE000,
  parameter logic [ADDR_W-1:0] PG0_MASK  = 24'hFFE3FF,
  parameter logic [ADDR_W-1:0] SCRATCH   = 24'hFFFFFF,
  parameter bit                ALIAS_EN  = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  input  region_e           region,
  input  logic [ADDR_W-1:0] rom_size,
  input  logic [ADDR_W-1:0] high_start,
  input  logic [ADDR_W-1:0] high_base,
  output logic [ADDR_W-1:0] offset
);
  logic [ADDR_W-1:0] high_addr;

  generate
    if (ALIAS_EN) begin : g_alias
      always_comb begin
        if (addr >= PG1_BASE)      high_addr = addr & PG1_MASK;
        else if (addr >= PG0_BASE) high_addr = addr & PG0_MASK;
        else                       high_addr = addr;
      end
    end else begin : g_flat
      assign high_addr = addr;
    end
  endgenerate

  always_comb begin
    unique case (region)
      RGN_BOOT: offset = addr & (rom_size - 1'b1);
      RGN_LOW:  offset = addr - LOW_FLOOR + rom_size;
      RGN_HIGH: offset = high_addr - high_start + high_base;
      default:  offset = SCRATCH;
    endcase
  end
endmodule

// File: rtl/sparse_region_mapper.sv
module sparse_region_mapper
  import mapper_pkg::*;
#(
  parameter int                IN_W      = 32,
  parameter int                ADDR_W    = 24,
  parameter logic [ADDR_W-1:0] LOW_FLOOR = 24'h100000,
  parameter logic [ADDR_W-1:0] SCRATCH   = 24'hFFFFFF,
  parameter bit                ALIAS_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [IN_W-1:0]   req_addr,
  input  logic [ADDR_W-1:0] cfg_rom_size,
  input  logic [ADDR_W-1:0] cfg_low_end,
  input  logic [ADDR_W-1:0] cfg_high_start,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic              rsp_fault
);
  logic [ADDR_W-1:0] addr_t;
  logic [ADDR_W-1:0] low_end_eff;
  logic [ADDR_W-1:0] high_base;
  logic [ADDR_W-1:0] next_offset;
  region_e           region;

  assign addr_t = req_addr[ADDR_W-1:0];

  generate
    if (IN_W > ADDR_W) begin : g_drop
      logic unused_upper;
      assign unused_upper = ^req_addr[IN_W-1:ADDR_W];
    end
  endgenerate

  mapper_cfg #(.ADDR_W(ADDR_W), .LOW_FLOOR(LOW_FLOOR)) cfg_i (
    .rom_size    (cfg_rom_size),
    .low_end     (cfg_low_end),
    .low_end_eff (low_end_eff),
    .high_base   (high_base)
  );

  mapper_classify #(.ADDR_W(ADDR_W), .LOW_FLOOR(LOW_FLOOR)) cls_i (
    .addr        (addr_t),
    .low_end_eff (low_end_eff),
    .high_start  (cfg_high_start),
    .region      (region)
  );

  mapper_offset #(
    .ADDR_W(ADDR_W), .LOW_FLOOR(LOW_FLOOR), .SCRATCH(SCRATCH), .ALIAS_EN(ALIAS_EN)
  ) off_i (
    .addr       (addr_t),
    .region     (region),
    .rom_size   (cfg_rom_size),
    .high_start (cfg_high_start),
    .high_base  (high_base),
    .offset     (next_offset)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_offset <= '0;
      rsp_fault  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_offset <= next_offset;
        rsp_fault  <= (region == RGN_GAP);
      end
    end
  end

  // R8: a result follows each request by exactly one cycle
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r8_valid_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R8: the result holds while no request arrives
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(rsp_offset) && $stable(rsp_fault)));
  // R6: a fault always points to the scratch offset
  a_r6_fault_scratch: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_offset == SCRATCH));
  // R6: an address in the gap is reported as a fault
  a_r6_gap_faults: assert property (@(posedge clk) disable iff (rst)
    (req_valid && addr_t >= low_end_eff && addr_t < cfg_high_start) |=> rsp_fault);
  // R2: the repeated boot image never leaves its own size
  a_r2_boot_bound: assert property (@(posedge clk) disable iff (rst)
    (req_valid && addr_t < LOW_FLOOR && $countones(cfg_rom_size) == 1)
      |=> (!rsp_fault && rsp_offset < $past(cfg_rom_size)));
endmodule

// File: tb/sparse_region_mapper_tb_top.sv
`timescale 1ns/1ps
module sparse_region_mapper_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [23:0] cfg_rom_size = 24'h040000;
  logic [23:0] cfg_low_end = 24'h140000;
  logic [23:0] cfg_high_start = 24'hFFC000;
  logic        rsp_valid;
  logic [23:0] rsp_offset;
  logic        rsp_fault;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  typedef struct {
    logic [23:0] off;
    logic        flt;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  sparse_region_mapper dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_rom_size(cfg_rom_size), .cfg_low_end(cfg_low_end),
    .cfg_high_start(cfg_high_start), .rsp_valid(rsp_valid),
    .rsp_offset(rsp_offset), .rsp_fault(rsp_fault)
  );

  task automatic check(input string tag, input logic [23:0] act_o, input logic act_f,
                       input logic [23:0] exp_o, input logic exp_f);
    checks++;
    if (act_o !== exp_o || act_f !== exp_f) begin
      fails++;
      $display("FAIL %s: offset=%06h fault=%0b expected offset=%06h fault=%0b",
               tag, act_o, act_f, exp_o, exp_f);
    end
  endtask

  // Drive one request at a falling edge and queue the value the requirements predict
  task automatic send(input logic [31:0] a, input logic [23:0] eo, input logic ef, input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    e.off = eo; e.flt = ef; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compare every result against the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R8: unexpected result offset=%06h expected none", rsp_offset);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, rsp_offset, rsp_fault, e.off, e.flt);
      end
    end
  end

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual cycles=%0d expected fewer", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 reset", rsp_offset, rsp_fault, 24'h0, 1'b0);
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: rsp_valid=%0b expected 0", rsp_valid);
    end

    // boot image 256 KB, low end 0x140000, high start 0xFFC000, high base 0x080000
    send(32'h0000_0123, 24'h000123, 1'b0, "R2 boot direct");
    send(32'h000C_0123, 24'h000123, 1'b0, "R2 boot mirror");
    send(32'hAB10_0010, 24'h040010, 1'b0, "R1 R3 upper bits dropped");
    send(32'h0013_FFFF, 24'h07FFFF, 1'b0, "R3 last low byte");
    send(32'h0014_0000, 24'hFFFFFF, 1'b1, "R6 first gap byte");
    send(32'h00FF_BFFF, 24'hFFFFFF, 1'b1, "R6 last gap byte");
    send(32'h00FF_C000, 24'h080000, 1'b0, "R4 first high byte");
    send(32'h00FF_D123, 24'h081123, 1'b0, "R4 high below pages");
    send(32'h00FF_E800, 24'h082000, 1'b0, "R5 lower page alias");
    send(32'h00FF_EC05, 24'h082005, 1'b0, "R5 lower page alias top");
    send(32'h00FF_F7FF, 24'h0833FF, 1'b0, "R5 upper page alias");
    send(32'hFFFF_FFFF, 24'h0833FF, 1'b0, "R1 R5 top of space");

    // R8: the held result survives idle cycles
    repeat (4) @(negedge clk);
    check("R8 hold", rsp_offset, rsp_fault, 24'h0833FF, 1'b0);
    send(32'h0020_0000, 24'hFFFFFF, 1'b1, "R6 fault then hold");
    repeat (3) @(negedge clk);
    check("R8 fault held", rsp_offset, rsp_fault, 24'hFFFFFF, 1'b1);

    // R7: a low end under 1 MB acts as 1 MB; 4 KB boot image
    @(negedge clk);
    cfg_rom_size = 24'h001000;
    cfg_low_end  = 24'h080000;
    send(32'h000F_FFFF, 24'h000FFF, 1'b0, "R2 small boot mirror");
    send(32'h0010_0000, 24'hFFFFFF, 1'b1, "R7 no low area");
    send(32'h00FF_C010, 24'h001010, 1'b0, "R7 high base uses clamp");

    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R8: results missing actual=%0d expected 0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule